// File: doc/BRIEF.md
# Successive-approximation converter readout controller

This block is the digital face of a successive-approximation converter. Two active-low control lines, a chip select and a read/convert line, are combined. A conversion starts once both are low together for a minimum hold time. From then on the busy line stays low for a fixed number of system clocks. At the end of that window the block loads a result word from a parallel stand-in port, because the analog decision logic is not modelled here.

While conversion n runs, the result of conversion n-1 leaves the block one bit at a time, most significant bit first. There are two clock modes. In self-clocked mode the block drives its own serial clock with exactly one pulse per bit, and each bit holds steady through both edges of its pulse. In external mode a host supplies the serial clock. The host may read the n-1 word during the conversion, or read the fresh word n once busy has returned high.

After the last bit, the data line carries a tag level that was captured when the conversion started. The first word produced after reset carries no real result, and a validity flag marks it as such.

Parameters:
- `CONV_CYCLES` sets the conversion length in clocks.
- `DCLK_HALF` sets the serial clock half-period in clocks. It must be at least 2, and 2·DCLK_HALF·WORD_W must be less than `CONV_CYCLES`.
- The hold time is `HOLD_NS` rounded up to whole periods of `CLK_PERIOD_NS`. With the defaults this is 5 clocks.

Top module: `sar_serial_readout`

## Requirements
- R1: The start request is the OR of `cs_n` and `rc_n` being low. Either line may fall first. A conversion begins at the HOLD_CYC-th consecutive clock edge that samples the request low (5 edges by default), and `busy_n` goes low after that edge.
- R2: A request that is low for fewer than HOLD_CYC consecutive edges starts no conversion, and `busy_n` stays high.
- R3: `busy_n` stays low for exactly CONV_CYCLES clock cycles (72 by default) and then returns high.
- R4: A request made while `busy_n` is low is ignored. A request still held low when the conversion ends starts nothing. The next conversion needs the request to be seen high while idle.
- R5: When `ext_clk_mode` is 0, `dclk` gives exactly WORD_W (16) high pulses during a conversion. Sampled on the rising edges, they carry the previous conversion's word, MSB first.
- R6: In self-clocked mode, `dclk` is high for DCLK_HALF cycles and low for DCLK_HALF cycles per bit. `sdata` does not change while `dclk` is high, nor in the cycle in which it falls.
- R7: Once the LSB has been sent, `sdata` equals the `tag_in` level sampled at the start edge. `dclk` stays low whenever `busy_n` is high.
- R8: `data_valid` is 0 for the word sent during the first conversion after reset, and 1 for every later word.
- R9: When `ext_clk_mode` is 1, `sdata` shows the previous word's MSB after the start. Each falling edge of `ext_sclk` moves it on by one bit. After WORD_W falling edges, `sdata` equals the latched tag.
- R10: When `ext_clk_mode` is 1 and a conversion ends, the new word is loaded with its MSB on `sdata`, and WORD_W further falling edges read it out. If an `ext_sclk` fall lands on that same edge, the load takes priority.
- R11: During and just after reset: `busy_n`=1, `dclk`=0, `sdata`=0, `data_valid`=0.
- R12: `dclk` stays 0 while `ext_clk_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Active-low read/convert line |
| ext_clk_mode | input | 1 | 1 = host supplies the serial clock, 0 = block drives `dclk` |
| ext_sclk | input | 1 | Host serial clock, synchronous to `clk`; data advances on its falling edge |
| tag_in | input | 1 | Level sampled at conversion start and shown after the LSB |
| result_in | input | WORD_W | Stand-in conversion result, loaded when a conversion ends |
| busy_n | output | 1 | Low while a conversion runs |
| sdata | output | 1 | Serial result data |
| dclk | output | 1 | Serial clock driven in self-clocked mode |
| data_valid | output | 1 | 1 when the word being sent is a real result |

## Verification
In external mode, the last edge of a conversion can coincide with a falling edge of the host clock. At that edge the block must either load the new word or move the old word on by one bit. The bench sets the host clock high right after a start and drops it on the negative edge just before the conversion's final clock edge. It passes the case when busy is high again, the data line already shows the MSB of the new word rather than the old word's second bit, and a full readout of 16 bits then returns the new word unchanged.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_RUN  = 1'b1
  } conv_state_e;
endpackage

// File: rtl/sar_start_qual.sv
// Qualifies the combined start request: it must stay low for HOLD_CYC edges
// while idle and must have been seen high while idle since the last start.
module sar_start_qual #(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rc_n,
  input  logic idle_i,
  output logic start_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  logic          req_low;
  logic [CW-1:0] hold_q, hold_d;
  logic          armed_q, armed_d;

  assign req_low = ~(cs_n | rc_n);

  always_comb begin
    hold_d  = hold_q;
    armed_d = armed_q;
    start_o = 1'b0;
    if (!idle_i) begin
      hold_d  = '0;
      armed_d = 1'b0;
    end else if (!req_low) begin
      hold_d  = '0;
      armed_d = 1'b1;
    end else if (armed_q) begin
      if (hold_q == HOLD_LAST) begin
        start_o = 1'b1;
        hold_d  = '0;
        armed_d = 1'b0;
      end else begin
        hold_d = hold_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/sar_conv_timer.sv
// Fixed-length conversion window; stands in for the bit-decision sequence.
module sar_conv_timer
  import sar_rd_pkg::*;
#(
  parameter int CONV_CYCLES = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_n_o,
  output logic done_o
);
  localparam int TW = $clog2(CONV_CYCLES);
  localparam logic [TW-1:0] T_LAST = TW'(CONV_CYCLES - 1);

  conv_state_e   st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign done_o   = (st_q == CV_RUN) && (cnt_q == T_LAST);
  assign busy_n_o = (st_q == CV_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      CV_IDLE: if (start_i) begin
        st_d  = CV_RUN;
        cnt_d = '0;
      end
      CV_RUN: begin
        if (done_o) st_d  = CV_IDLE;
        else        cnt_d = cnt_q + TW'(1);
      end
      default: st_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CV_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sar_out_shifter.sv
// Result store and serial output path for both clocking modes.
module sar_out_shifter #(
  parameter int WORD_W    = 16,
  parameter int DCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode_i,
  input  logic              ext_sclk_i,
  input  logic              tag_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              sdata_o,
  output logic              dclk_o,
  output logic              valid_o
);
  localparam int IW = $clog2(WORD_W + 1);
  localparam int PW = $clog2(2 * DCLK_HALF);
  localparam logic [IW-1:0] IDX_END   = IW'(WORD_W);
  localparam logic [PW-1:0] PH_LAST   = PW'(2 * DCLK_HALF - 1);
  localparam logic [PW-1:0] PH_HI_END = PW'(DCLK_HALF);

  logic [WORD_W-1:0] res_q, res_d, sh_q, sh_d;
  logic              have_q, have_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic              tag_q, tag_d;
  logic              valid_q, valid_d;
  logic              sclk_q;
  logic              dclk_q, dclk_d;
  logic              shifting, int_step, ext_step;

  assign shifting = (idx_q != IDX_END);
  assign int_step = !ext_mode_i && shifting && (ph_q == PH_LAST);
  assign ext_step = ext_mode_i && shifting && sclk_q && !ext_sclk_i;

  always_comb begin
    res_d   = res_q;
    have_d  = have_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    ph_d    = ph_q;
    tag_d   = tag_q;
    valid_d = valid_q;
    if (start_i) begin
      sh_d    = res_q;
      idx_d   = '0;
      ph_d    = '0;
      tag_d   = tag_i;
      valid_d = have_q;
    end else if (done_i && ext_mode_i) begin
      sh_d    = result_i;
      idx_d   = '0;
      ph_d    = '0;
      valid_d = 1'b1;
    end else if (int_step || ext_step) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      idx_d = idx_q + IW'(1);
      ph_d  = '0;
    end else if (!ext_mode_i && shifting) begin
      ph_d = ph_q + PW'(1);
    end
    if (done_i) begin
      res_d  = result_i;
      have_d = 1'b1;
    end
    dclk_d = !ext_mode_i && (idx_d != IDX_END) && (ph_d != '0) && (ph_d <= PH_HI_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      have_q  <= 1'b0;
      sh_q    <= '0;
      idx_q   <= IDX_END;
      ph_q    <= '0;
      tag_q   <= 1'b0;
      valid_q <= 1'b0;
      sclk_q  <= 1'b0;
      dclk_q  <= 1'b0;
    end else begin
      res_q   <= res_d;
      have_q  <= have_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      ph_q    <= ph_d;
      tag_q   <= tag_d;
      valid_q <= valid_d;
      sclk_q  <= ext_sclk_i;
      dclk_q  <= dclk_d;
    end
  end

  assign sdata_o = shifting ? sh_q[WORD_W-1] : tag_q;
  assign dclk_o  = dclk_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sar_serial_readout.sv
module sar_serial_readout #(
  parameter int WORD_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int HOLD_NS       = 50,
  parameter int CONV_CYCLES   = 72,
  parameter int DCLK_HALF     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              ext_clk_mode,
  input  logic              ext_sclk,
  input  logic              tag_in,
  input  logic [WORD_W-1:0] result_in,
  output logic              busy_n,
  output logic              sdata,
  output logic              dclk,
  output logic              data_valid
);
  localparam int HOLD_CYC = (HOLD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       start_w, done_w, busy_n_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  sar_start_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cs_n    (cs_n),
    .rc_n    (rc_n),
    .idle_i  (busy_n_w),
    .start_o (start_w)
  );

  sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_w),
    .busy_n_o (busy_n_w),
    .done_o   (done_w)
  );

  sar_out_shifter #(.WORD_W(WORD_W), .DCLK_HALF(DCLK_HALF)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ext_mode_i (ext_clk_mode),
    .ext_sclk_i (ext_sclk),
    .tag_i      (tag_in),
    .result_i   (result_in),
    .start_i    (start_w),
    .done_i     (done_w),
    .sdata_o    (sdata),
    .dclk_o     (dclk),
    .valid_o    (data_valid)
  );

  assign busy_n = busy_n_w;
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 72
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rc_n,
  input logic ext_clk_mode,
  input logic busy_n,
  input logic sdata,
  input logic dclk
);
  localparam int LW = $clog2(CONV_CYCLES + 2);
  localparam int RW = $clog2(WORD_W + 2);

  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rise_cnt;
  logic          dclk_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      rise_cnt <= '0;
      dclk_q   <= 1'b0;
      busy_q   <= 1'b1;
    end else begin
      dclk_q <= dclk;
      busy_q <= busy_n;
      if (busy_n) low_cnt <= '0;
      else        low_cnt <= low_cnt + LW'(1);
      if (busy_q && !busy_n)  rise_cnt <= '0;
      else if (dclk && !dclk_q) rise_cnt <= rise_cnt + RW'(1);
    end
  end

  p_start_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!(cs_n | rc_n)));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == LW'(CONV_CYCLES)));

  p_pulse_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= RW'(WORD_W));

  p_pulse_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $rose(busy_n)) |-> (rise_cnt == RW'(WORD_W)));

  p_bit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $past(dclk)) |-> $stable(sdata));

  p_dclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !dclk);

  p_ext_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_mode && $past(ext_clk_mode)) |-> !dclk);
endmodule

bind sar_serial_readout sar_readout_chk #(
  .WORD_W      (WORD_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .rc_n         (rc_n),
  .ext_clk_mode (ext_clk_mode),
  .busy_n       (busy_n),
  .sdata        (sdata),
  .dclk         (dclk)
);

// File: tb/tb_sar_serial_readout.sv
module tb_sar_serial_readout;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;
  localparam int CONV       = 72;
  localparam int NVEC       = 6;
  // each entry: {ext_mode, tag, result[15:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 16'hA5C3},
    {1'b0, 1'b0, 16'h3C96},
    {1'b1, 1'b1, 16'hF00F},
    {1'b0, 1'b1, 16'h8001},
    {1'b1, 1'b0, 16'h7FFE},
    {1'b0, 1'b0, 16'h1234}
  };

  logic clk, rst_n, cs_n, rc_n, ext_clk_mode, ext_sclk, tag_in;
  logic [15:0] result_in;
  logic busy_n, sdata, dclk, data_valid;

  int checks, failures, wd_cycles;
  logic [15:0] prev_res, word;

  sar_serial_readout dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n),
    .ext_clk_mode(ext_clk_mode), .ext_sclk(ext_sclk), .tag_in(tag_in),
    .result_in(result_in), .busy_n(busy_n), .sdata(sdata), .dclk(dclk),
    .data_valid(data_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp<=100000", wd_cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R1: request low on both lines; busy falls on the HOLD-th sampling edge
  task automatic do_start(input bit rc_first, input bit keep_low);
    @(negedge clk);
    if (rc_first) rc_n = 1'b0; else cs_n = 1'b0;
    @(negedge clk);
    if (rc_first) cs_n = 1'b0; else rc_n = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    chk(busy_n == 1'b1, "R1 busy still high before hold time", busy_n, 1);
    @(negedge clk);
    chk(busy_n == 1'b0, "R1 busy low after hold time", busy_n, 0);
    if (!keep_low) begin
      cs_n = 1'b1;
      rc_n = 1'b1;
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && busy_n == 1'b0; k++) @(negedge clk);
  endtask

  task automatic ext_read(output logic [15:0] w, output bit dclk_seen);
    w = '0;
    dclk_seen = 1'b0;
    for (int b = 0; b < 16; b++) begin
      w = {w[14:0], sdata};
      if (dclk) dclk_seen = 1'b1;
      ext_sclk = 1'b1;
      @(negedge clk);
      ext_sclk = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    int rises, cyc;
    bit prev_d, lastbit, stable_ok, bad, dseen;
    checks = 0; failures = 0; wd_cycles = 0;
    rst_n = 1'b0; cs_n = 1'b1; rc_n = 1'b1; ext_clk_mode = 1'b0;
    ext_sclk = 1'b0; tag_in = 1'b0; result_in = '0; prev_res = '0;
    repeat (3) @(negedge clk);
    chk({busy_n, dclk, sdata, data_valid} == 4'b1000, "R11 reset outputs",
        {busy_n, dclk, sdata, data_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_n, dclk, sdata, data_valid} == 4'b1000, "R11 after release",
        {busy_n, dclk, sdata, data_valid}, 4'b1000);

    for (int i = 0; i < NVEC; i++) begin
      ext_clk_mode = VEC[i][17];
      tag_in       = VEC[i][16];
      result_in    = VEC[i][15:0];
      @(negedge clk);
      do_start(i[0], 1'b0);
      tag_in = ~VEC[i][16];
      chk(data_valid == (i > 0), "R8 validity flag", data_valid, (i > 0));
      if (!VEC[i][17]) begin
        cyc = 0; rises = 0; prev_d = 1'b0; lastbit = 1'b0; stable_ok = 1'b1; word = '0;
        while (busy_n == 1'b0 && cyc < 1000) begin
          if (dclk && !prev_d) begin
            rises++;
            word = {word[14:0], sdata};
            lastbit = sdata;
          end else if (prev_d && sdata != lastbit) begin
            stable_ok = 1'b0;
          end
          prev_d = dclk;
          cyc++;
          @(negedge clk);
        end
        chk(cyc == CONV, "R3 busy low length", cyc, CONV);
        chk(rises == 16, "R5 dclk pulse count", rises, 16);
        if (i > 0) chk(word == prev_res, "R5 previous word MSB first", word, prev_res);
        chk(stable_ok, "R6 data stable over pulse", stable_ok, 1);
        chk(sdata == VEC[i][16], "R7 tag after LSB", sdata, VEC[i][16]);
        chk(dclk == 1'b0, "R7 dclk low when idle", dclk, 0);
      end else begin
        ext_read(word, dseen);
        if (i > 0) chk(word == prev_res, "R9 previous word in ext mode", word, prev_res);
        chk(sdata == VEC[i][16], "R9 tag after LSB", sdata, VEC[i][16]);
        chk(busy_n == 1'b0, "R9 read done inside conversion", busy_n, 0);
        wait_idle();
        chk(sdata == VEC[i][15], "R10 new MSB after end", sdata, VEC[i][15]);
        ext_read(word, bad);
        dseen = dseen | bad;
        chk(word == VEC[i][15:0], "R10 new word after end", word, VEC[i][15:0]);
        chk(!dseen, "R12 dclk quiet in ext mode", dseen, 0);
      end
      prev_res = VEC[i][15:0];
      repeat (2) @(negedge clk);
    end

    // R2: request too short
    ext_clk_mode = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!busy_n) bad = 1'b1;
    end
    chk(!bad, "R2 short request ignored", bad, 0);

    // R4: requests during a conversion and a request held through its end
    result_in = 16'h5AA5;
    do_start(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    rc_n = 1'b1;
    @(negedge clk);
    rc_n = 1'b0;
    wait_idle();
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (!busy_n) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R4 held request does not restart", bad, 0);
    cs_n = 1'b1; rc_n = 1'b1;
    @(negedge clk);
    do_start(1'b1, 1'b0);
    wait_idle();
    prev_res = 16'h5AA5;

    // R10 corner: host clock fall on the conversion's last edge
    ext_clk_mode = 1'b1;
    result_in = 16'h4B2D;
    repeat (2) @(negedge clk);
    do_start(1'b1, 1'b0);
    ext_sclk = 1'b1;
    repeat (CONV - 1) @(negedge clk);
    ext_sclk = 1'b0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R10 conversion ended", busy_n, 1);
    chk(sdata == 1'b0, "R10 load wins over shift", sdata, 0);
    ext_read(word, dseen);
    chk(word == 16'h4B2D, "R10 full new word after collision", word, 16'h4B2D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule